// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave-side protocol engine for a 2048-byte memory on a two-wire serial bus. A fast system clock samples SCL and SDA. The block finds start and stop conditions and decodes the address byte and the word-address byte. It answers with acknowledges, shifts read data out through an SDA pull-low output, and keeps the 11-bit internal address counter. The memory array is outside the block. The block reads it through a byte-wide read port.

Written bytes go to an external write engine one at a time, each with its own address. A commit pulse at the stop condition tells the engine to program the bytes it has gathered. A drop pulse tells it to discard them. While the engine reports busy, the block refuses every address byte. A host uses this to poll for the end of a programming cycle.

The address byte works as follows. Its upper nibble is a fixed device type. The three bits after it are the top three word-address bits. Its lowest bit selects the direction.

Top module: `tw_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start. It returns the engine to the address-byte phase from any state. A rising SDA while SCL is high is a stop. It ends the transfer and returns the engine to idle. SDA changes while SCL is low are data bits, sampled on SCL rising edges, most significant bit first.
- R2: The engine acknowledges an address byte only when bits 7:4 equal 1010. On a mismatch it gives no acknowledge and ignores all bus activity until the next start. The address counter is left unchanged.
- R3: In the address byte, bits 3:1 are word-address bits 10:8 and bit 0 is the direction (1 = read, 0 = write). In a write, the second byte gives word-address bits 7:0, and the counter is loaded with the joined 11-bit value.
- R4: The engine acknowledges an accepted address byte and every byte received in write mode. It does this by pulling SDA low for the whole ninth SCL clock. The pull output changes only while SCL is low.
- R5: Each received data byte is reported on the write port with the current counter value as its address. After that, the low 4 counter bits increment and wrap inside the 16-byte page, and the upper 7 bits do not change. A stop after at least one data byte gives exactly one commit pulse.
- R6: In read mode the engine sends 8 bits, most significant first, and then releases SDA. An acknowledge from the master starts the next byte. With no acknowledge, the engine stops driving SDA until the next start.
- R7: After each byte sent, all 11 counter bits increment, so 0x7FF rolls over to 0x000.
- R8: A read-mode address byte sends the byte at the current counter value. The counter holds the last accessed address plus one: page-wrapped after a write, full-width after a read. The three high bits of a read-mode address byte are ignored.
- R9: While the write engine reports busy, no address byte is acknowledged.
- R10: A start that arrives after data bytes of an unfinished write gives a drop pulse and no commit. Memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level (asynchronous) |
| sda_in | input | 1 | Serial data line level (asynchronous) |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| rd_addr | output | 11 | Memory read address (the address counter) |
| rd_data | input | 8 | Memory byte at rd_addr, combinational |
| wr_valid | output | 1 | One-cycle pulse: a data byte was received |
| wr_addr | output | 11 | Address of the reported byte |
| wr_data | output | 8 | Reported byte |
| wr_commit | output | 1 | One-cycle pulse: program the gathered bytes |
| wr_drop | output | 1 | One-cycle pulse: discard the gathered bytes |
| wr_busy | input | 1 | Write engine is programming |

## Verification
On the same SCL falling edge, a received data byte is captured for the write port and the page counter steps on to the next address. So the reported address must be the value from before the step, even on the edge where the low nibble wraps from 0xF to 0x0. The bench provokes this with a four-byte page write that starts two bytes before a page end. It then reads back both the page start and the page end. Both readbacks must show the wrapped placement, and so must the current-address read that follows.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int          DEF_ADDR_W = 11;
    localparam int          DEF_PAGE_W = 4;
    localparam logic [3:0]  DEV_ID     = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } ctrl_state_e;

    // line events seen on the synchronized bus levels
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic dev_match(input logic [7:0] b);
        return b[7:4] == DEV_ID;
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    // idle bus level is high, so every stage resets high
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_all,
    input  logic              inc_page,
    output logic [ADDR_W-1:0] addr
);

    localparam int ROW_W = ADDR_W - PAGE_W;

    logic [ROW_W-1:0]  row;
    logic [PAGE_W-1:0] col;

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
            col <= '0;
        end else if (load) begin
            {row, col} <= load_val;
        end else if (inc_all) begin
            {row, col} <= {row, col} + ADDR_W'(1);
        end else if (inc_page) begin
            col <= col + PAGE_W'(1);
        end
    end

    assign addr = {row, col};

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        rd_data,
    input  logic              wr_busy,
    output ctrl_state_e       state,
    output logic              sda_pull,
    output logic              ctr_load,
    output logic [ADDR_W-1:0] ctr_load_val,
    output logic              inc_all,
    output logic              inc_page,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              wr_drop
);

    localparam int HI_W = ADDR_W - 8;

    logic [3:0]      bit_cnt;
    logic [7:0]      rx_sr;
    logic [7:0]      tx_sr;
    logic [HI_W-1:0] hi_bits;
    logic            rd_mode;
    logic            host_ack;
    logic            pending;
    logic            byte_done;

    assign byte_done    = ev.scl_fall && (bit_cnt == 4'd8);
    assign ctr_load     = (state == ST_WADDR) && byte_done;
    assign ctr_load_val = {hi_bits, rx_sr};
    assign inc_page     = (state == ST_WDATA) && byte_done;
    assign inc_all      = (state == ST_RDATA) && byte_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            hi_bits   <= '0;
            rd_mode   <= 1'b0;
            host_ack  <= 1'b0;
            pending   <= 1'b0;
            sda_pull  <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
            wr_drop   <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            wr_drop   <= 1'b0;
            if (ev.start) begin
                state    <= ST_DEV;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
                if (pending) begin
                    wr_drop <= 1'b1;
                    pending <= 1'b0;
                end
            end else if (ev.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                if (pending) begin
                    wr_commit <= 1'b1;
                    pending   <= 1'b0;
                end
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (ev.scl_rise) begin
                            rx_sr   <= {rx_sr[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                if (dev_match(rx_sr) && !wr_busy) begin
                                    sda_pull <= 1'b1;
                                    hi_bits  <= rx_sr[HI_W:1];
                                    rd_mode  <= rx_sr[0];
                                    state    <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WADDR) begin
                                sda_pull <= 1'b1;
                                state    <= ST_WADDR_ACK;
                            end else begin
                                sda_pull <= 1'b1;
                                wr_valid <= 1'b1;
                                wr_addr  <= addr;
                                wr_data  <= rx_sr;
                                pending  <= 1'b1;
                                state    <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (ev.scl_fall) begin
                            if (rd_mode) begin
                                tx_sr    <= rd_data;
                                sda_pull <= ~rd_data[7];
                                bit_cnt  <= '0;
                                state    <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_WADDR;
                            end
                        end
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            sda_pull <= 1'b0;
                            state    <= ST_RACK;
                        end else if (ev.scl_fall) begin
                            tx_sr    <= {tx_sr[6:0], 1'b0};
                            sda_pull <= ~tx_sr[6];
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            host_ack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (host_ack) begin
                                tx_sr    <= rd_data;
                                sda_pull <= ~rd_data[7];
                                bit_cnt  <= '0;
                                state    <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int PAGE_W      = DEF_PAGE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              wr_drop,
    input  logic              wr_busy
);

    line_ev_t          ev;
    ctrl_state_e       state;
    logic [ADDR_W-1:0] addr;
    logic              ctr_load;
    logic [ADDR_W-1:0] ctr_load_val;
    logic              inc_all;
    logic              inc_page;

    tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    tw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .addr         (addr),
        .rd_data      (rd_data),
        .wr_busy      (wr_busy),
        .state        (state),
        .sda_pull     (sda_pull),
        .ctr_load     (ctr_load),
        .ctr_load_val (ctr_load_val),
        .inc_all      (inc_all),
        .inc_page     (inc_page),
        .wr_valid     (wr_valid),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_commit    (wr_commit),
        .wr_drop      (wr_drop)
    );

    tw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (ctr_load_val),
        .inc_all  (inc_all),
        .inc_page (inc_page),
        .addr     (addr)
    );

    assign rd_addr = addr;

endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk
    import tw_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_lvl,
    input logic              sda_pull,
    input ctrl_state_e       state,
    input logic              wr_busy,
    input logic [ADDR_W-1:0] addr,
    input logic              inc_all,
    input logic              inc_page,
    input logic              wr_valid,
    input logic              wr_commit,
    input logic              wr_drop
);

    // R4: the pull output only moves while the clock line is low
    assert_pull_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_lvl);

    // R9: an address acknowledge never follows a busy decision cycle
    assert_busy_noack_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV_ACK && $past(state) != ST_DEV_ACK && sda_pull) |-> !$past(wr_busy));

    // R7: read stepping is a full-width modular increment
    assert_read_step_R7: assert property (@(posedge clk) disable iff (rst)
        inc_all |=> (addr - $past(addr)) == ADDR_W'(1));

    // R5: write stepping keeps the page and wraps the column
    assert_page_step_R5: assert property (@(posedge clk) disable iff (rst)
        inc_page |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) &&
                     ((addr[PAGE_W-1:0] - $past(addr[PAGE_W-1:0])) == PAGE_W'(1)));

    // R5, R10: byte, commit and drop pulses never coincide
    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_valid, wr_commit, wr_drop}));

endmodule

bind tw_mem_slave tw_mem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (ev.scl),
    .sda_pull  (sda_pull),
    .state     (state),
    .wr_busy   (wr_busy),
    .addr      (addr),
    .inc_all   (inc_all),
    .inc_page  (inc_page),
    .wr_valid  (wr_valid),
    .wr_commit (wr_commit),
    .wr_drop   (wr_drop)
);

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb;

    localparam int P        = 20;
    localparam int BUSY_CYC = 1500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic [10:0] rd_addr;
    logic [7:0]  rd_data;
    logic        wr_valid, wr_commit, wr_drop, wr_busy;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;
    wire         sda_line = sda_m & ~sda_pull;

    tw_mem_slave u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .wr_drop(wr_drop), .wr_busy(wr_busy)
    );

    // array and write engine model, plus the reference contents
    logic [7:0]  mem     [0:2047];
    logic [7:0]  exp_mem [0:2047];
    logic [10:0] q_a[$];
    logic [7:0]  q_d[$];
    int          busy_left = 0;
    int          exp_ptr   = 0;

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
    end

    assign rd_data = mem[rd_addr];
    assign wr_busy = (busy_left != 0);

    always @(posedge clk) begin
        if (wr_valid) begin
            q_a.push_back(wr_addr);
            q_d.push_back(wr_data);
        end
        if (wr_drop) begin
            q_a.delete();
            q_d.delete();
        end
        if (wr_commit) begin
            for (int k = 0; k < q_a.size(); k++) mem[q_a[k]] = q_d[k];
            q_a.delete();
            q_d.delete();
            busy_left = BUSY_CYC;
        end else if (busy_left > 0) begin
            busy_left = busy_left - 1;
        end
    end

    int n_chk  = 0;
    int n_fail = 0;
    int viol   = 0;
    logic may_drive = 1'b0;

    // per-clock comparison: the slave may pull only inside its slots
    always @(negedge clk) begin
        if (!rst && !may_drive && sda_pull) viol++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        may_drive = 1'b0;
        sda_m = 1'b1; wait_clk(P);
        scl_m = 1'b1; wait_clk(P);
        sda_m = 1'b0; wait_clk(P);
        scl_m = 1'b0; wait_clk(8);
    endtask

    task automatic bus_stop();
        may_drive = 1'b0;
        sda_m = 1'b0; wait_clk(P);
        scl_m = 1'b1; wait_clk(P);
        sda_m = 1'b1; wait_clk(P);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        may_drive = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(P);
            scl_m = 1'b1; wait_clk(P);
            scl_m = 1'b0;
            if (i == 0) may_drive = 1'b1;
            wait_clk(8);
        end
        sda_m = 1'b1; wait_clk(P);
        scl_m = 1'b1; wait_clk(P/2);
        ack = !sda_line;
        wait_clk(P/2);
        scl_m = 1'b0; wait_clk(8);
    endtask

    task automatic recv_byte(input logic do_ack, output logic [7:0] b);
        may_drive = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(P);
            scl_m = 1'b1; wait_clk(P/2);
            b[i] = sda_line;
            wait_clk(P/2);
            scl_m = 1'b0; wait_clk(8);
        end
        if (!do_ack) may_drive = 1'b0;
        sda_m = !do_ack; wait_clk(P);
        scl_m = 1'b1; wait_clk(P);
        scl_m = 1'b0; wait_clk(8);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input int hi, input bit rnw);
        return {4'b1010, 3'(hi), rnw};
    endfunction

    // poll with write-mode address bytes until acknowledged
    task automatic wait_ready();
        logic a;
        a = 1'b0;
        for (int i = 0; i < 40 && !a; i++) begin
            bus_start();
            send_byte(dev(0, 0), a);
            bus_stop();
            if (!a) wait_clk(200);
        end
        check(a == 1'b1, "R9 poll acknowledged after busy ends", a, 1);
    endtask

    task automatic write_bytes(input int start, input int n, input logic [7:0] first);
        logic a;
        int   p;
        bus_start();
        send_byte(dev(start >> 8, 0), a);
        check(a, "R2 address byte acknowledged", a, 1);
        send_byte(8'(start), a);
        check(a, "R4 word address acknowledged", a, 1);
        p = start;
        for (int k = 0; k < n; k++) begin
            send_byte(first + 8'(k * 17), a);
            check(a, "R4 data byte acknowledged", a, 1);
            exp_mem[p] = first + 8'(k * 17);
            p = (p & 11'h7F0) | ((p + 1) & 11'hF);
        end
        exp_ptr = p;
        bus_stop();
    endtask

    task automatic read_seq(input int start, input int n, input string req);
        logic       a;
        logic [7:0] d;
        int         p;
        bus_start();
        send_byte(dev(start >> 8, 0), a);
        send_byte(8'(start), a);
        bus_start();
        send_byte(dev(0, 1), a);
        check(a, "R3 read address byte acknowledged", a, 1);
        p = start;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            check(d == exp_mem[p], req, d, exp_mem[p]);
            p = (p + 1) & 11'h7FF;
        end
        exp_ptr = p;
        bus_stop();
    endtask

    task automatic read_current(input int hi, input string req);
        logic       a;
        logic [7:0] d;
        bus_start();
        send_byte(dev(hi, 1), a);
        recv_byte(1'b0, d);
        check(d == exp_mem[exp_ptr], req, d, exp_mem[exp_ptr]);
        exp_ptr = (exp_ptr + 1) & 11'h7FF;
        bus_stop();
    endtask

    initial begin
        logic       a;
        logic [7:0] d;
        int         lows;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        check(sda_pull == 1'b0, "R1 reset: bus released", sda_pull, 0);
        check({wr_valid, wr_commit, wr_drop} == 3'b000, "R5 reset: no write pulses",
              {wr_valid, wr_commit, wr_drop}, 0);

        // byte write, then an immediate poll while busy
        write_bytes(11'h123, 1, 8'hA5);
        bus_start();
        send_byte(dev(0, 0), a);
        check(a == 1'b0, "R9 no acknowledge while busy", a, 0);
        bus_stop();
        wait_ready();

        // random read and current-address read (high bits ignored)
        read_seq(11'h123, 1, "R3 random read data");
        read_current(5, "R8 current-address read after read");

        // page write crossing the page end: 0x20E,0x20F,0x200,0x201
        write_bytes(11'h20E, 4, 8'h11);
        wait_ready();
        read_current(0, "R8 current-address read after page write");
        read_seq(11'h20E, 4, "R5 page end bytes then R7 next page");
        read_seq(11'h200, 2, "R5 wrapped bytes at page start");

        // full-width rollover
        read_seq(11'h7FE, 3, "R7 sequential read rolls over");
        read_current(0, "R7 counter after rollover");

        // mismatching device type is ignored until the next start
        bus_start();
        send_byte(8'hB2, a);
        check(a == 1'b0, "R2 mismatch not acknowledged", a, 0);
        send_byte(8'h00, a);
        check(a == 1'b0, "R2 bytes after mismatch ignored", a, 0);
        bus_stop();
        read_current(0, "R2 counter untouched by mismatch");

        // a start after a data byte drops the write
        bus_start();
        send_byte(dev(0, 0), a);
        send_byte(8'h50, a);
        send_byte(8'h5A, a);
        check(a, "R4 data byte acknowledged before abort", a, 1);
        bus_start();
        send_byte(dev(0, 1), a);
        check(a, "R1 repeated start returns to address phase", a, 1);
        recv_byte(1'b0, d);
        check(d == exp_mem[11'h051], "R10 counter stepped past dropped byte", d, exp_mem[11'h051]);
        bus_stop();
        bus_start();
        send_byte(dev(0, 0), a);
        check(a, "R10 no programming cycle after drop", a, 1);
        bus_stop();
        read_seq(11'h050, 1, "R10 dropped byte not written");

        // after a missing master acknowledge the slave stays off the line
        bus_start();
        send_byte(dev(0, 1), a);
        recv_byte(1'b0, d);
        lows = 0;
        for (int i = 0; i < 9; i++) begin
            sda_m = 1'b1; wait_clk(P);
            scl_m = 1'b1; wait_clk(P/2);
            if (!sda_line) lows++;
            wait_clk(P/2);
            scl_m = 1'b0; wait_clk(8);
        end
        check(lows == 0, "R6 released after no acknowledge", lows, 0);
        bus_stop();

        check(viol == 0, "R6 pull only inside slave slots", viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule